// File: doc/BRIEF.md
# Auto-Increment Word Programming Sequencer

This block is the control core behind multi-byte word programming in a serial NOR flash slave. A serial front-end hands it a decoded opcode, an address, two data bytes, chip-select edge pulses and a flag that says whether every bit of the command arrived. The sequencer decides whether the command is legal in the present state. It then issues two-byte program requests to an abstract array-write port, keeps the write-enable latch and the word-mode flag, and walks the internal address upward by one word per command.

Only the first word command carries an address. Every later word command carries just two data bytes, and the word lands at the next even address. The mode ends when write-disable is accepted, or by itself once the highest unprotected address has been written. The address never wraps. The protection boundary comes in as an input. A down-counter loaded with a parameter value models the program time. An optional hardware ready/busy indication can drive the serial data-out pin while chip select is low during word mode.

Top module: `aaiw_seq`

## Requirements
- R1: Opcode ADh accepted while the write-enable latch is 1, word mode is off and no program is running turns word mode on. It issues a request at the command address with bit 0 cleared. Without the latch set, the command is ignored.
- R2: In a request, `wr_data[15:8]` holds the first data byte, which belongs at the even address. `wr_data[7:0]` holds the second byte, which belongs at the odd address (`wr_addr`+1).
- R3: An ADh accepted in word mode ignores its address field. It programs the word that follows the previous one, at the previous address plus 2.
- R4: A command acts only on the `cs_rise` pulse with `cmd_full`=1. `wr_req` rises in the cycle after that pulse. A command with `cmd_full`=0 has no effect.
- R5: In word mode only ADh, 05h (read status, no state change) and 04h are acted on. Every other opcode, including 06h, 70h and 80h, is ignored.
- R6: An accepted 04h clears both the write-enable latch and word mode.
- R7: When a word that ends at address `prot_lo`-1, or at the top of the address space, finishes programming, word mode and the write-enable latch clear. Later ADh commands issue no request.
- R8: `busy` is 1 for exactly PROG_CYCLES cycles, starting in the cycle `wr_req` is 1. Any command other than 05h that arrives while `busy`=1 is dropped without a flag.
- R9: After 70h is accepted outside word mode, `rb_oe` is 1 whenever word mode is on and chip select is low (between `cs_fall` and `cs_rise`). In that state `rb_level` equals the inverse of `busy`. After 80h is accepted outside word mode, `rb_oe` stays 0.
- R10: An ADh whose word is not wholly below `prot_lo` is ignored. No request is issued and word mode stays off.
- R11: An accepted 06h outside word mode sets the write-enable latch.
- R12: After reset, `wel`, `aai`, `busy`, `wr_req` and `rb_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_fall | input | 1 | Pulse: chip select went low |
| cs_rise | input | 1 | Pulse: chip select went high (execute point) |
| cmd_full | input | 1 | All bits of the command were shifted in |
| cmd_op | input | 8 | Decoded opcode |
| cmd_addr | input | AW | Address field of the command |
| cmd_d0 | input | 8 | First data byte |
| cmd_d1 | input | 8 | Second data byte |
| prot_lo | input | AW+1 | Lowest protected address (2^AW means none protected) |
| wr_req | output | 1 | One-cycle program request to the array port |
| wr_addr | output | AW | Even word address of the request |
| wr_data | output | 16 | Even byte in [15:8], odd byte in [7:0] |
| busy | output | 1 | Program in progress |
| wel | output | 1 | Write-enable latch |
| aai | output | 1 | Word programming mode flag |
| rb_oe | output | 1 | Drive data-out pin with ready/busy level |
| rb_level | output | 1 | Ready/busy level: 0 busy, 1 ready |

## Verification
A scoreboard queues every expected request and compares it against the port, and a byte-wide reference memory confirms where each byte lands. The stimulus has four strands. The first is a sequence started from an odd address whose follow-on commands carry a misleading address field, which separates an internal pointer from use of the command address. The second is commands thrown in during the program window and illegal opcodes sent in word mode, which separate the drop rules from normal acceptance. The third is a start inside the protected region, next to a run that climbs up to a lowered boundary and a single word at the very top of the space, which shows an exit without wrap from an exit that comes too early or too late. The fourth is chip-select pulses with the ready/busy option on and off, which shows when the data-out pin is driven.

// File: rtl/aaiw_pkg.sv
package aaiw_pkg;
  localparam logic [7:0] OP_WORD   = 8'hAD;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_RB_ON  = 8'h70;
  localparam logic [7:0] OP_RB_OFF = 8'h80;

  typedef struct packed {
    logic enter;
    logic step;
    logic wren;
    logic wrdi;
    logic rb_on;
    logic rb_off;
  } aaiw_act_t;
endpackage

// File: rtl/aaiw_decode.sv
module aaiw_decode
  import aaiw_pkg::*;
(
  input  logic       go,
  input  logic [7:0] op,
  input  logic       busy,
  input  logic       wel,
  input  logic       aai,
  input  logic       tgt_ok,
  output aaiw_act_t  act
);
  always_comb begin
    act = '0;
    if (go && !busy) begin
      if (aai) begin
        unique case (op)
          OP_WORD: act.step = tgt_ok;
          OP_WRDI: act.wrdi = 1'b1;
          default: ;
        endcase
      end else begin
        unique case (op)
          OP_WORD:   act.enter  = wel & tgt_ok;
          OP_WREN:   act.wren   = 1'b1;
          OP_WRDI:   act.wrdi   = 1'b1;
          OP_RB_ON:  act.rb_on  = 1'b1;
          OP_RB_OFF: act.rb_off = 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/aaiw_timer.sv
module aaiw_timer #(
  parameter int PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = CW'(PROG_CYCLES - 1);
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/aaiw_rbpin.sv
module aaiw_rbpin (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_fall,
  input  logic cs_rise,
  input  logic rb_on,
  input  logic rb_off,
  input  logic aai,
  input  logic busy,
  output logic rb_oe,
  output logic rb_level
);
  logic cs_act_q, cs_act_d;
  logic en_q, en_d;

  always_comb begin
    cs_act_d = cs_act_q;
    if (cs_rise)      cs_act_d = 1'b0;
    else if (cs_fall) cs_act_d = 1'b1;
    en_d = en_q;
    if (rb_on)       en_d = 1'b1;
    else if (rb_off) en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_act_q <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      cs_act_q <= cs_act_d;
      en_q     <= en_d;
    end
  end

  assign rb_oe    = en_q & aai & cs_act_q;
  assign rb_level = ~busy;
endmodule

// File: rtl/aaiw_seq.sv
module aaiw_seq
  import aaiw_pkg::*;
#(
  parameter int AW          = 19,
  parameter int PROG_CYCLES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_fall,
  input  logic          cs_rise,
  input  logic          cmd_full,
  input  logic [7:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_d0,
  input  logic [7:0]    cmd_d1,
  input  logic [AW:0]   prot_lo,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [15:0]   wr_data,
  output logic          busy,
  output logic          wel,
  output logic          aai,
  output logic          rb_oe,
  output logic          rb_level
);
  localparam int PW = AW + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic          wel_q, wel_d, aai_q, aai_d, last_q, last_d, req_q;
  logic [AW-1:0] nxt_q, nxt_d, addr_q;
  logic [15:0]   data_q;
  logic          tmr_busy, tmr_done, go_prog;
  logic [AW-1:0] word_start, tgt;
  logic [PW-1:0] tgt_next;
  logic          tgt_ok, tgt_last;
  aaiw_act_t     act;

  assign word_start = cmd_addr & ~AW'(1);
  assign tgt        = aai_q ? nxt_q : word_start;
  assign tgt_next   = {1'b0, tgt} + PW'(2);
  assign tgt_ok     = (tgt_next <= prot_lo);
  assign tgt_last   = ((tgt_next + PW'(2)) > prot_lo);

  aaiw_decode u_dec (
    .go     (cs_rise & cmd_full),
    .op     (cmd_op),
    .busy   (tmr_busy),
    .wel    (wel_q),
    .aai    (aai_q),
    .tgt_ok (tgt_ok),
    .act    (act)
  );

  assign go_prog = act.enter | act.step;

  aaiw_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_s),
    .start (go_prog),
    .busy  (tmr_busy),
    .done  (tmr_done)
  );

  always_comb begin
    wel_d  = wel_q;
    aai_d  = aai_q;
    nxt_d  = nxt_q;
    last_d = last_q;
    if (act.wren) wel_d = 1'b1;
    if (act.wrdi) begin
      wel_d  = 1'b0;
      aai_d  = 1'b0;
      last_d = 1'b0;
    end
    if (go_prog) begin
      aai_d  = 1'b1;
      nxt_d  = tgt_next[AW-1:0];
      last_d = tgt_last;
    end
    if (tmr_done && last_q) begin
      aai_d  = 1'b0;
      wel_d  = 1'b0;
      last_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      wel_q  <= 1'b0;
      aai_q  <= 1'b0;
      last_q <= 1'b0;
      nxt_q  <= '0;
      req_q  <= 1'b0;
    end else begin
      wel_q  <= wel_d;
      aai_q  <= aai_d;
      last_q <= last_d;
      nxt_q  <= nxt_d;
      req_q  <= go_prog;
    end
  end

  // request payload, loaded only when a word is launched
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (go_prog) begin
      addr_q <= tgt;
      data_q <= {cmd_d0, cmd_d1};
    end
  end

  aaiw_rbpin u_rb (
    .clk      (clk),
    .rst_n    (rst_s),
    .cs_fall  (cs_fall),
    .cs_rise  (cs_rise),
    .rb_on    (act.rb_on),
    .rb_off   (act.rb_off),
    .aai      (aai_q),
    .busy     (tmr_busy),
    .rb_oe    (rb_oe),
    .rb_level (rb_level)
  );

  assign wr_req  = req_q;
  assign wr_addr = addr_q;
  assign wr_data = data_q;
  assign busy    = tmr_busy;
  assign wel     = wel_q;
  assign aai     = aai_q;
endmodule

// File: rtl/aaiw_seq_chk.sv
module aaiw_seq_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_req,
  input logic [AW-1:0] wr_addr,
  input logic          busy,
  input logic          wel,
  input logic          aai,
  input logic          rb_oe
);
  AST_REQ_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> aai); // R1
  AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (wr_addr[0] == 1'b0)); // R2
  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !$past(busy)); // R8
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req); // R8
  AST_MODE_HOLDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    aai |-> wel); // R6
  AST_EXIT_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aai) |-> !wel); // R7
  AST_RB_ONLY_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    rb_oe |-> aai); // R9
endmodule

bind aaiw_seq aaiw_seq_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_req  (wr_req),
  .wr_addr (wr_addr),
  .busy    (busy),
  .wel     (wel),
  .aai     (aai),
  .rb_oe   (rb_oe)
);

// File: tb/aaiw_seq_bench.sv
module aaiw_seq_bench;
  localparam int AW = 8;
  localparam int PC = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, cs_fall, cs_rise, cmd_full;
  logic [7:0]    cmd_op, cmd_d0, cmd_d1;
  logic [AW-1:0] cmd_addr;
  logic [AW:0]   prot_lo;
  logic          wr_req, busy, wel, aai, rb_oe, rb_level;
  logic [AW-1:0] wr_addr;
  logic [15:0]   wr_data;

  aaiw_seq #(.AW(AW), .PROG_CYCLES(PC)) u_aaiw_seq (
    .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .cmd_full(cmd_full), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_d0(cmd_d0), .cmd_d1(cmd_d1), .prot_lo(prot_lo),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
    .wel(wel), .aai(aai), .rb_oe(rb_oe), .rb_level(rb_level)
  );

  logic [AW+15:0] expq[$];
  logic [7:0]     mem [0:(1<<AW)-1];
  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one framed command; pushes the expected request when one is due
  task automatic send(input logic [7:0] op, input logic [AW-1:0] a,
                      input logic [7:0] b0, input logic [7:0] b1, input bit full,
                      input bit want, input logic [AW-1:0] ea);
    @(negedge clk) cs_fall = 1'b1;
    @(negedge clk) cs_fall = 1'b0;
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_d0 = b0; cmd_d1 = b1;
    cmd_full = full; cs_rise = 1'b1;
    if (want) expq.push_back({ea, b0, b1});
    @(negedge clk) cs_rise = 1'b0; cmd_full = 1'b0;
  endtask

  task automatic op1(input logic [7:0] op);
    send(op, '0, 8'h00, 8'h00, 1'b1, 1'b0, '0);
  endtask

  task automatic cs_down();
    @(negedge clk) cs_fall = 1'b1;
    @(negedge clk) cs_fall = 1'b0;
  endtask

  task automatic cs_up();
    @(negedge clk) cs_rise = 1'b1; cmd_full = 1'b0;
    @(negedge clk) cs_rise = 1'b0;
  endtask

  task automatic settle();
    repeat (PC + 2) @(negedge clk);
  endtask

  // monitor: pops expected requests and fills the reference memory
  always @(negedge clk) begin
    if (rst_n && wr_req) begin
      n_chk++;
      if (expq.size() == 0) begin
        n_err++;
        $display("FAIL R1/R7 unexpected request: actual=%h expected=none", {wr_addr, wr_data});
      end else begin
        logic [AW+15:0] e;
        e = expq.pop_front();
        if ({wr_addr, wr_data} !== e) begin
          n_err++;
          $display("FAIL R2/R3 request: actual=%h expected=%h", {wr_addr, wr_data}, e);
        end
      end
      mem[wr_addr]       = wr_data[15:8];
      mem[wr_addr + 1'b1] = wr_data[7:0];
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'hFF;
    rst_n = 1'b0; cs_fall = 1'b0; cs_rise = 1'b0; cmd_full = 1'b0;
    cmd_op = '0; cmd_addr = '0; cmd_d0 = '0; cmd_d1 = '0;
    prot_lo = 9'h100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk("R12 wel", wel, 0); chk("R12 aai", aai, 0);
    chk("R12 busy", busy, 0); chk("R12 rb_oe", rb_oe, 0);

    // R1 no latch: ignored
    send(8'hAD, 8'h10, 8'h11, 8'h22, 1'b1, 1'b0, '0);
    chk("R1 ignored without latch", aai, 0);

    op1(8'h06);
    chk("R11 latch set", wel, 1);
    op1(8'h70);

    // R1/R2/R4 entry from odd address
    send(8'hAD, 8'h11, 8'hA1, 8'hB2, 1'b1, 1'b1, 8'h10);
    chk("R4 request next cycle", wr_req, 1);
    chk("R1 mode on", aai, 1);
    chk("R8 busy start", busy, 1);
    cs_down();
    chk("R9 pin driven", rb_oe, 1);
    chk("R9 level busy", rb_level, 0);
    repeat (PC - 3) @(negedge clk);
    chk("R8 busy last cycle", busy, 1);
    @(negedge clk);
    chk("R8 busy over", busy, 0);
    chk("R9 level ready", rb_level, 1);
    cs_up();
    chk("R9 released on cs high", rb_oe, 0);

    // R3 address field ignored; R8 drop during busy
    send(8'hAD, 8'h80, 8'hC3, 8'hD4, 1'b1, 1'b1, 8'h12);
    op1(8'h04);
    settle();
    chk("R8 dropped wrdi wel", wel, 1);
    chk("R8 dropped wrdi aai", aai, 1);

    // R5 illegal opcode in mode; R4 incomplete
    op1(8'h80);
    cs_down();
    chk("R5 80h ignored in mode", rb_oe, 1);
    cs_up();
    send(8'hAD, 8'h00, 8'h55, 8'h66, 1'b0, 1'b0, '0);
    chk("R4 incomplete no program", busy, 0);
    send(8'hAD, 8'h00, 8'hE5, 8'hF6, 1'b1, 1'b1, 8'h14);
    settle();

    // R6 write-disable ends mode
    op1(8'h04);
    chk("R6 wel cleared", wel, 0);
    chk("R6 aai cleared", aai, 0);

    // R9 disable then program: pin stays off
    op1(8'h80);
    op1(8'h06);
    send(8'hAD, 8'h40, 8'h01, 8'h02, 1'b1, 1'b1, 8'h40);
    cs_down();
    chk("R9 disabled pin", rb_oe, 0);
    cs_up();
    settle();
    op1(8'h04);

    // R10 protected start
    prot_lo = 9'h040;
    op1(8'h06);
    send(8'hAD, 8'h50, 8'h77, 8'h88, 1'b1, 1'b0, '0);
    chk("R10 no program", busy, 0);
    chk("R10 mode off", aai, 0);

    // R7 exit at protection boundary
    send(8'hAD, 8'h3C, 8'h31, 8'h32, 1'b1, 1'b1, 8'h3C);
    settle();
    chk("R7 still in mode", aai, 1);
    send(8'hAD, 8'h00, 8'h33, 8'h34, 1'b1, 1'b1, 8'h3E);
    settle();
    chk("R7 mode exit", aai, 0);
    chk("R7 latch exit", wel, 0);
    send(8'hAD, 8'h00, 8'h35, 8'h36, 1'b1, 1'b0, '0);
    chk("R7 no wrap", busy, 0);

    // R7 exit at top of space
    prot_lo = 9'h100;
    op1(8'h06);
    send(8'hAD, 8'hFF, 8'h9A, 8'h9B, 1'b1, 1'b1, 8'hFE);
    settle();
    chk("R7 top exit", aai, 0);

    // R2 reference memory placement
    chk("R2 mem10", mem[8'h10], 8'hA1); chk("R2 mem11", mem[8'h11], 8'hB2);
    chk("R3 mem12", mem[8'h12], 8'hC3); chk("R3 mem13", mem[8'h13], 8'hD4);
    chk("R2 memFF", mem[8'hFF], 8'h9B);
    chk("R1 queue drained", expq.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule